// File: doc/BRIEF.md
# Two-Class Interrupt Status Controller

This block gathers interrupt conditions from two classes of source, bus-side events and DMA-side events, into three status registers that clear when the host reads them. There are two bus-side registers, A and B, and one DMA register. A summary register shows which class still has an unserviced condition, and a single request line `irq` goes to the host.

Some bus-side bits are marked fatal by a parameter. When a fatal condition arrives while data flows in from the bus, the block does not raise it at once. It first asks for the data FIFO to be drained to memory, and posts the condition only after the drain handshake completes. Fatal conditions during outbound transfers, and all DMA conditions, post at once.

The host reaches the registers through a synchronous 8-bit port with a 3-bit address. Read data appears one cycle after the read strobe. A control register gives self-clearing FIFO-clear strobes.

Top module: `irq_status_ctrl`

## Requirements
- R1: The summary register (address 0) has bit 0 set when any bit of bus status A (address 1) or bus status B (address 2) is set, and bit 1 set when any event bit [6:0] of the DMA status register (address 3) is set. Its other bits read 0.
- R2: Conditions of both classes can be pending at once, and the summary then reads 0x03.
- R3: `rdata` holds the register selected by `addr` in the cycle after `rd_en`. A read of bus status A or B returns its set bits and clears them in the same edge.
- R4: A read of the DMA status register returns event bits [6:0] and clears them.
- R5: Bit 7 of the DMA status register is the live `fifo_empty` input. A read does not clear it, and it never drives `irq`.
- R6: A fatal bus condition with `rx_inbound`=1 asserts `drain_req` and stays out of status until a cycle with `drain_done`=1, after which it is set in status. Fatal bits default to bits 0 and 7 of A and bit 0 of B. Non-fatal bits post at once.
- R7: A fatal bus condition with `rx_inbound`=0 sets its status bit at the next edge, and `drain_req` stays low. DMA events also set their bits at the next edge.
- R8: Writing the control register (address 4) with bit 2 set gives a one-cycle `clr_dma_fifo` pulse after the write edge. Writing it with bit 1 set gives the same for `clr_bus_fifo`. The register reads back 0.
- R9: An event that arrives in the same cycle as a read-to-clear of its register remains set after the read.
- R10: `irq` is high when any status bit is set whose matching bit is 1 in its enable mask. The masks are A at address 5, B at address 6 and DMA at address 7, where bits [6:0] are used. A masked bit still latches and still sets its summary bit.
- R11: The mask registers can be read and written, and they reset to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after rd_en |
| bus_evt_a | input | 8 | Bus-side event pulses, group A |
| bus_evt_b | input | 8 | Bus-side event pulses, group B |
| dma_evt | input | 7 | DMA-side event pulses |
| rx_inbound | input | 1 | 1 while data is received from the bus |
| fifo_empty | input | 1 | Live data FIFO empty flag |
| drain_req | output | 1 | Request to drain the FIFO to memory |
| drain_done | input | 1 | Drain completed |
| clr_dma_fifo | output | 1 | One-cycle DMA FIFO clear strobe |
| clr_bus_fifo | output | 1 | One-cycle bus FIFO clear strobe |
| irq | output | 1 | Interrupt request to host |

## Verification
The hardest cases to reach from the ports are a fatal inbound condition held behind the drain handshake while a read of the same register clears the non-fatal bits around it, and an event that lands in the same cycle as the read that clears its register. To reach the first, the stimulus pulses a fatal bit and a non-fatal bit together with `rx_inbound` high. It reads the register twice while `drain_req` is up, and only then returns `drain_done`. To reach the second, the stimulus drives `rd_en` and the event in the same cycle and confirms the event on the following read.

// File: rtl/irqsc_pkg.sv
package irqsc_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DMA_EW = DW - 1;

  typedef enum logic [AW-1:0] {
    A_SUMMARY = 3'd0,
    A_BUSA    = 3'd1,
    A_BUSB    = 3'd2,
    A_DMA     = 3'd3,
    A_CTRL    = 3'd4,
    A_MASKA   = 3'd5,
    A_MASKB   = 3'd6,
    A_MASKD   = 3'd7
  } reg_addr_e;

  localparam int CTRL_CLR_DMA = 2;
  localparam int CTRL_CLR_BUS = 1;

  // clear first, then new events win
  function automatic logic [DW-1:0] rc_next(input logic [DW-1:0] cur,
                                            input logic [DW-1:0] clr,
                                            input logic [DW-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_enabled(input logic [DW-1:0] st,
                                       input logic [DW-1:0] msk);
    return |(st & msk);
  endfunction
endpackage

// File: rtl/irqsc_status_bank.sv
module irqsc_status_bank
  import irqsc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] stat_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= rc_next(stat_o, clr_i, set_i);
  end

  // R9: a new event survives a coincident clear
  p_set_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));

  // R3: a full clear with no new event empties the register
  p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '1 && set_i == '0) |=> (stat_o == '0));
endmodule

// File: rtl/irqsc_fatal_defer.sv
module irqsc_fatal_defer
  import irqsc_pkg::*;
#(
  parameter logic [DW-1:0] FATAL = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic          inbound_i,
  input  logic          drain_done_i,
  output logic [DW-1:0] pass_o,
  output logic [DW-1:0] held_o
);
  logic [DW-1:0] defer_now;
  logic [DW-1:0] release_now;

  assign defer_now   = inbound_i ? (evt_i & FATAL) : '0;
  assign release_now = drain_done_i ? held_o : '0;
  assign pass_o      = (evt_i & ~defer_now) | release_now;

  always_ff @(posedge clk) begin
    if (!rst_n) held_o <= '0;
    else        held_o <= (held_o & ~release_now) | defer_now;
  end

  // R6: held bits stay held until the drain handshake
  p_hold_until_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o != '0 && !drain_done_i) |=> ((held_o & $past(held_o)) == $past(held_o)));

  // R6: the handshake hands every held bit to status
  p_release_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_done_i) |-> ((pass_o & held_o) == held_o));

  // R7: outbound events are never held back
  p_outbound_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inbound_i) |-> ((pass_o & evt_i) == evt_i));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqsc_pkg::*;
#(
  parameter logic [DW-1:0] FATAL_A = 8'h81,
  parameter logic [DW-1:0] FATAL_B = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     bus_evt_a,
  input  logic [DW-1:0]     bus_evt_b,
  input  logic [DMA_EW-1:0] dma_evt,
  input  logic              rx_inbound,
  input  logic              fifo_empty,
  output logic              drain_req,
  input  logic              drain_done,
  output logic              clr_dma_fifo,
  output logic              clr_bus_fifo,
  output logic              irq
);
  logic [DW-1:0] pass_a, pass_b, held_a, held_b;
  logic [DW-1:0] stat_a, stat_b, stat_d;
  logic [DW-1:0] clr_a, clr_b, clr_d;
  logic [DW-1:0] mask_a, mask_b, mask_d;
  logic          bus_pend, dma_pend;
  logic          ctrl_wr;
  reg_addr_e     ra;

  assign ra = reg_addr_e'(addr);

  irqsc_fatal_defer #(.FATAL(FATAL_A)) u_defer_a (
    .clk(clk), .rst_n(rst_n), .evt_i(bus_evt_a), .inbound_i(rx_inbound),
    .drain_done_i(drain_done), .pass_o(pass_a), .held_o(held_a));

  irqsc_fatal_defer #(.FATAL(FATAL_B)) u_defer_b (
    .clk(clk), .rst_n(rst_n), .evt_i(bus_evt_b), .inbound_i(rx_inbound),
    .drain_done_i(drain_done), .pass_o(pass_b), .held_o(held_b));

  assign drain_req = (held_a != '0) || (held_b != '0);

  assign clr_a = (rd_en && ra == A_BUSA) ? '1 : '0;
  assign clr_b = (rd_en && ra == A_BUSB) ? '1 : '0;
  assign clr_d = (rd_en && ra == A_DMA)  ? '1 : '0;

  irqsc_status_bank u_bank_a (.clk(clk), .rst_n(rst_n), .set_i(pass_a),
    .clr_i(clr_a), .stat_o(stat_a));
  irqsc_status_bank u_bank_b (.clk(clk), .rst_n(rst_n), .set_i(pass_b),
    .clr_i(clr_b), .stat_o(stat_b));
  irqsc_status_bank u_bank_d (.clk(clk), .rst_n(rst_n), .set_i({1'b0, dma_evt}),
    .clr_i(clr_d), .stat_o(stat_d));

  assign bus_pend = (stat_a != '0) || (stat_b != '0);
  assign dma_pend = stat_d[DMA_EW-1:0] != '0;

  assign irq = any_enabled(stat_a, mask_a) || any_enabled(stat_b, mask_b) ||
               any_enabled({1'b0, stat_d[DMA_EW-1:0]}, {1'b0, mask_d[DMA_EW-1:0]});

  assign ctrl_wr = wr_en && ra == A_CTRL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_a       <= '1;
      mask_b       <= '1;
      mask_d       <= '1;
      clr_dma_fifo <= 1'b0;
      clr_bus_fifo <= 1'b0;
    end else begin
      clr_dma_fifo <= ctrl_wr && wdata[CTRL_CLR_DMA];
      clr_bus_fifo <= ctrl_wr && wdata[CTRL_CLR_BUS];
      if (wr_en && ra == A_MASKA) mask_a <= wdata;
      if (wr_en && ra == A_MASKB) mask_b <= wdata;
      if (wr_en && ra == A_MASKD) mask_d <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (ra)
        A_SUMMARY: rdata <= {6'b0, dma_pend, bus_pend};
        A_BUSA:    rdata <= stat_a;
        A_BUSB:    rdata <= stat_b;
        A_DMA:     rdata <= {fifo_empty, stat_d[DMA_EW-1:0]};
        A_MASKA:   rdata <= mask_a;
        A_MASKB:   rdata <= mask_b;
        A_MASKD:   rdata <= mask_d;
        default:   rdata <= '0;
      endcase
    end
  end

  // R8: a strobe only follows a control write
  p_strobe_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_dma_fifo || clr_bus_fifo) |-> $past(ctrl_wr));

  // R10: the request needs a pending class behind it
  p_irq_needs_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (bus_pend || dma_pend));

  // R7: outbound bus events land in status at the next edge
  p_outbound_immediate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_inbound && bus_evt_a != '0) |=> ((stat_a & $past(bus_evt_a)) == $past(bus_evt_a)));

  // R5: the empty flag alone never requests service
  p_fe_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_pend && !dma_pend) |-> !irq);
endmodule

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;
  logic       clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, bus_evt_a = 0, bus_evt_b = 0;
  logic [6:0] dma_evt = 0;
  logic       rx_inbound = 0, fifo_empty = 0, drain_done = 0;
  logic       drain_req, clr_dma_fifo, clr_bus_fifo, irq;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       due = 0;

  always #2 clk = ~clk;

  irq_status_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // scoreboard monitor: result is due the cycle after a read strobe
  always @(posedge clk) due <= rd_en;
  always @(negedge clk) begin
    if (due) begin
      if (exp_q.size() == 0) chk("queue", 8'hEE, 8'h00);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_en = 1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input logic [7:0] ea, input logic [7:0] eb, input logic [6:0] ed);
    @(negedge clk);
    bus_evt_a = ea; bus_evt_b = eb; dma_evt = ed;
    @(negedge clk);
    bus_evt_a = 0; bus_evt_b = 0; dma_evt = 0;
  endtask

  initial begin
    #800000;
    n_fail++; n_run++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
    chk("R6 reset drain_req", {7'b0, drain_req}, 8'h00);
    rd(3'd0, 8'h00, "R1 reset summary");
    rd(3'd5, 8'hFF, "R11 reset mask A");
    rd(3'd6, 8'hFF, "R11 reset mask B");

    // R3/R1 non-fatal bus event
    pulse(8'h12, 0, 0);
    rd(3'd0, 8'h01, "R1 bus pending");
    rd(3'd1, 8'h12, "R3 read A");
    rd(3'd1, 8'h00, "R3 A cleared");
    rd(3'd0, 8'h00, "R1 summary clear");

    // R5 empty flag alone
    fifo_empty = 1;
    @(negedge clk);
    chk("R5 empty no irq", {7'b0, irq}, 8'h00);
    // R4 DMA events
    pulse(0, 0, 7'h05);
    chk("R7 dma immediate irq", {7'b0, irq}, 8'h01);
    rd(3'd0, 8'h02, "R1 dma pending");
    rd(3'd3, 8'h85, "R4 read dma");
    rd(3'd3, 8'h80, "R5 empty not cleared");
    fifo_empty = 0;
    rd(3'd3, 8'h00, "R5 live empty");

    // R2 both classes
    pulse(0, 8'h04, 7'h01);
    rd(3'd0, 8'h03, "R2 both pending");
    chk("R2 irq", {7'b0, irq}, 8'h01);
    rd(3'd2, 8'h04, "R3 read B");
    rd(3'd3, 8'h01, "R4 read dma");

    // R7 outbound fatal
    pulse(8'h01, 0, 0);
    chk("R7 no drain", {7'b0, drain_req}, 8'h00);
    rd(3'd1, 8'h01, "R7 fatal immediate");

    // R6 inbound fatal deferral
    rx_inbound = 1;
    pulse(8'h82, 0, 0);
    chk("R6 drain_req", {7'b0, drain_req}, 8'h01);
    rd(3'd1, 8'h02, "R6 nonfatal posts");
    rd(3'd1, 8'h00, "R6 fatal held");
    chk("R6 still draining", {7'b0, drain_req}, 8'h01);
    @(negedge clk); drain_done = 1;
    @(negedge clk); drain_done = 0;
    chk("R6 drain ends", {7'b0, drain_req}, 8'h00);
    rd(3'd1, 8'h80, "R6 fatal after drain");
    rx_inbound = 0;

    // R9 event during clearing read
    pulse(0, 8'h01, 0);
    @(negedge clk);
    rd_en = 1; addr = 3'd2; bus_evt_b = 8'h10;
    exp_q.push_back(8'h01); tag_q.push_back("R9 old value");
    @(negedge clk);
    rd_en = 0; bus_evt_b = 0;
    rd(3'd2, 8'h10, "R9 event kept");

    // R10 mask
    wr(3'd5, 8'h00);
    pulse(8'h02, 0, 0);
    chk("R10 masked irq", {7'b0, irq}, 8'h00);
    rd(3'd0, 8'h01, "R10 still pending");
    wr(3'd5, 8'h02);
    chk("R10 unmasked irq", {7'b0, irq}, 8'h01);
    rd(3'd1, 8'h02, "R10 latched");

    // R8 strobes
    @(negedge clk);
    wr_en = 1; addr = 3'd4; wdata = 8'h06;
    @(negedge clk);
    wr_en = 0;
    chk("R8 both strobes", {6'b0, clr_dma_fifo, clr_bus_fifo}, 8'h03);
    @(negedge clk);
    chk("R8 self clear", {6'b0, clr_dma_fifo, clr_bus_fifo}, 8'h00);
    @(negedge clk);
    wr_en = 1; addr = 3'd4; wdata = 8'h04;
    @(negedge clk);
    wr_en = 0;
    chk("R8 dma only", {6'b0, clr_dma_fifo, clr_bus_fifo}, 8'h02);
    rd(3'd4, 8'h00, "R8 ctrl reads 0");

    // R11 mask write
    wr(3'd7, 8'h3C);
    rd(3'd7, 8'h3C, "R11 mask D");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule